// File: doc/BRIEF.md
# Dual-Clock Power Mode Controller

This block sits beside a small processor core that has a fast and a slow oscillator. It decides which oscillators run and when the core receives its clock. Software reaches it through two write ports. A clock-configuration write carries four control bits. A power-control write carries the halt and idle request bits. The controller follows three clock modes: fast only, slow only, and dual, where the core runs fast and the slow clock feeds the idle timer. The dual mode can only be entered by following an ordered sequence, and that sequence depends on the mode being left.

A halt or idle request is held until the core marks the end of an instruction cycle. Halt stops the fast oscillator and the idle-timer clock. A wakeup event does not release the core at once: it first starts a fixed start-up window of 256 instruction cycles, counted only while the fast oscillator reports ready. Idle leaves both oscillators running and ends when the idle timer signals that its window has elapsed. An active-low reset returns everything to fast mode and running.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_code is 00, pwr_state is 00 (run), core_clk_en, fast_osc_en and idle_tmr_en are 1, slow_osc_en is 0, and the stored fast-enable bit is 1 while the slow-enable bit is 0.
- R2: In fast mode (00), a config write with bit 2 (dual enable) set moves to dual mode (10) only if bit 1 (slow enable) was already 1 from an earlier write and slow_rdy is 1 during the write. Otherwise the mode is unchanged.
- R3: In slow mode (01), a config write with bit 3 (core-clock select) at 0 moves to dual mode only if bit 0 (fast enable) was already 1 from an earlier write and fast_rdy is 1 during the write. Otherwise the mode stays 01.
- R4: In fast mode, a config write with bit 3 set moves to slow mode under the same slow-enable and slow_rdy conditions as R2, with dual enable taking priority. Dual mode is left only by reset.
- R5: slow_osc_en is 1 in slow or dual mode, or when the stored slow-enable bit is 1. Every config write stores bits 0 and 1 as the fast-enable and slow-enable bits.
- R6: A power write with bit 7 set latches a halt request, and one with bit 6 set latches an idle request. On a cycle where pwr_state is run and cyc_end is 1, a pending halt takes the state to halt (01), otherwise a pending idle takes it to idle (10). Both pending requests are then cleared.
- R7: In halt, core_clk_en, fast_osc_en and idle_tmr_en are 0. slow_osc_en keeps the value given by R5, so it stays 1 in dual mode.
- R8: A wakeup event in halt enters the start-up state (11). In this state fast_osc_en is 1 and core_clk_en is 0. The state returns to run after 1280 clock cycles with fast_rdy at 1, which is 256 instruction cycles of 5 fast periods. Cycles with fast_rdy at 0 are not counted.
- R9: Reset during halt returns the block to fast mode and to run.
- R10: While halt_dis is 1, halt-request writes are discarded, and the following cyc_end leaves pwr_state at run.
- R11: In idle, core_clk_en is 0 while fast_osc_en and idle_tmr_en stay 1. idle_tick returns the state to run at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Clock-configuration write strobe |
| cfg_wdata | input | 4 | Bit 0 fast enable, bit 1 slow enable, bit 2 dual enable, bit 3 core-clock select slow |
| port_we | input | 1 | Power-control write strobe |
| port_wdata | input | 8 | Bit 7 halt request, bit 6 idle request |
| cyc_end | input | 1 | Instruction-cycle boundary strobe from the core |
| fast_rdy | input | 1 | Fast oscillator stable |
| slow_rdy | input | 1 | Slow oscillator stable |
| wake_evt | input | 1 | Wakeup event pulse |
| idle_tick | input | 1 | Idle timer window elapsed |
| halt_dis | input | 1 | Option bit: ignore halt requests |
| core_clk_en | output | 1 | Core clock gate enable |
| fast_osc_en | output | 1 | Fast oscillator enable |
| slow_osc_en | output | 1 | Slow oscillator enable |
| idle_tmr_en | output | 1 | Idle timer clock enable |
| mode_code | output | 2 | 00 fast, 01 slow, 10 dual |
| pwr_state | output | 2 | 00 run, 01 halt, 10 idle, 11 start-up |

## Verification
The bench builds the block with its default parameters: 5 fast periods per instruction cycle and a 256-instruction start-up window. This means the full 1280-cycle window is exercised, together with its stretching while fast_rdy drops. A behavioural model advances a single integer counter, which is a different structure from the nested counters in the design. Both entry sequences into dual mode are driven out of order before they are driven in order. Halt-versus-idle priority, the halt-disable option and reset out of halt are each visited.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_HS   = 2'b00,
    MODE_LS   = 2'b01,
    MODE_DUAL = 2'b10
  } clk_mode_e;

  typedef enum logic [1:0] {
    PS_RUN   = 2'b00,
    PS_HALT  = 2'b01,
    PS_IDLE  = 2'b10,
    PS_START = 2'b11
  } pwr_state_e;

  localparam int CFG_FAST_ON = 0;
  localparam int CFG_SLOW_ON = 1;
  localparam int CFG_DUAL_EN = 2;
  localparam int CFG_CSEL    = 3;
  localparam int PORT_HALT   = 7;
  localparam int PORT_IDLE   = 6;

  // Next clock mode for one config write, judged against the enable bits
  // stored before this write.
  function automatic clk_mode_e mode_step(clk_mode_e cur, logic [3:0] wd,
                                          logic fast_on_q, logic slow_on_q,
                                          logic fast_rdy, logic slow_rdy);
    clk_mode_e nxt = cur;
    case (cur)
      MODE_HS: begin
        if (slow_on_q && slow_rdy) begin
          if (wd[CFG_DUAL_EN])   nxt = MODE_DUAL;
          else if (wd[CFG_CSEL]) nxt = MODE_LS;
        end
      end
      MODE_LS: if (!wd[CFG_CSEL] && fast_on_q && fast_rdy) nxt = MODE_DUAL;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pmc_clk_mode.sv
module pmc_clk_mode
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       fast_rdy,
  input  logic       slow_rdy,
  output clk_mode_e  mode,
  output logic       fast_on,
  output logic       slow_on,
  output logic       ev_mode_chg
);

  clk_mode_e mode_nxt;

  always_comb begin
    mode_nxt = mode;
    if (cfg_we)
      mode_nxt = mode_step(mode, cfg_wdata, fast_on, slow_on, fast_rdy, slow_rdy);
  end

  assign ev_mode_chg = (mode_nxt != mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_HS;
      fast_on <= 1'b1;
      slow_on <= 1'b0;
    end else begin
      mode <= mode_nxt;
      if (cfg_we) begin
        fast_on <= cfg_wdata[CFG_FAST_ON];
        slow_on <= cfg_wdata[CFG_SLOW_ON];
      end
    end
  end

endmodule

// File: rtl/pmc_start_delay.sv
module pmc_start_delay #(
  parameter int CPI = 5,
  parameter int DLY = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast_rdy,
  output logic done
);

  localparam int SUB_W = $clog2(CPI + 1);
  localparam int INS_W = $clog2(DLY + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CPI - 1);
  localparam logic [INS_W-1:0] INS_LAST = INS_W'(DLY - 1);

  logic [SUB_W-1:0] sub_q;
  logic [INS_W-1:0] ins_q;
  logic             sub_wrap;

  assign sub_wrap = run && fast_rdy && (sub_q == SUB_LAST);
  assign done     = sub_wrap && (ins_q == INS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      ins_q <= '0;
    end else if (!run) begin
      sub_q <= '0;
      ins_q <= '0;
    end else if (fast_rdy) begin
      sub_q <= sub_wrap ? '0 : sub_q + 1'b1;
      if (sub_wrap) ins_q <= ins_q + 1'b1;
    end
  end

endmodule

// File: rtl/pmc_pwr_fsm.sv
module pmc_pwr_fsm
  import pmc_pkg::*;
#(
  parameter int CPI = 5,
  parameter int DLY = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_set,
  input  logic       idle_set,
  input  logic       cyc_end,
  input  logic       wake_evt,
  input  logic       idle_tick,
  input  logic       fast_rdy,
  output pwr_state_e state,
  output logic       ev_take
);

  logic halt_q, idle_q, take_halt, take_idle, start_done;

  assign take_halt = (state == PS_RUN) && cyc_end && halt_q;
  assign take_idle = (state == PS_RUN) && cyc_end && !halt_q && idle_q;
  assign ev_take   = take_halt || take_idle;

  pmc_start_delay #(.CPI(CPI), .DLY(DLY)) delay_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state == PS_START),
    .fast_rdy (fast_rdy),
    .done     (start_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PS_RUN;
      halt_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      halt_q <= (halt_q || halt_set) && !ev_take;
      idle_q <= (idle_q || idle_set) && !ev_take;
      case (state)
        PS_RUN: begin
          if (take_halt)      state <= PS_HALT;
          else if (take_idle) state <= PS_IDLE;
        end
        PS_HALT:  if (wake_evt)   state <= PS_START;
        PS_START: if (start_done) state <= PS_RUN;
        PS_IDLE:  if (idle_tick)  state <= PS_RUN;
        default:  state <= PS_RUN;
      endcase
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CPI = 5,
  parameter int DLY = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       port_we,
  input  logic [7:0] port_wdata,
  input  logic       cyc_end,
  input  logic       fast_rdy,
  input  logic       slow_rdy,
  input  logic       wake_evt,
  input  logic       idle_tick,
  input  logic       halt_dis,
  output logic       core_clk_en,
  output logic       fast_osc_en,
  output logic       slow_osc_en,
  output logic       idle_tmr_en,
  output logic [1:0] mode_code,
  output logic [1:0] pwr_state
);

  clk_mode_e  mode;
  pwr_state_e state;
  logic fast_on, slow_on, ev_mode_chg, ev_take;
  logic halt_set, idle_set;
  logic unused_port_bits;

  assign unused_port_bits = ^{port_wdata[5:0], ev_mode_chg, ev_take};
  assign halt_set = port_we && port_wdata[PORT_HALT] && !halt_dis;
  assign idle_set = port_we && port_wdata[PORT_IDLE];

  pmc_clk_mode mode_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .fast_rdy    (fast_rdy),
    .slow_rdy    (slow_rdy),
    .mode        (mode),
    .fast_on     (fast_on),
    .slow_on     (slow_on),
    .ev_mode_chg (ev_mode_chg)
  );

  pmc_pwr_fsm #(.CPI(CPI), .DLY(DLY)) pwr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_set  (halt_set),
    .idle_set  (idle_set),
    .cyc_end   (cyc_end),
    .wake_evt  (wake_evt),
    .idle_tick (idle_tick),
    .fast_rdy  (fast_rdy),
    .state     (state),
    .ev_take   (ev_take)
  );

  assign core_clk_en = (state == PS_RUN);
  assign fast_osc_en = (state != PS_HALT) &&
                       ((state == PS_START) || (mode != MODE_LS) || fast_on);
  assign slow_osc_en = (mode != MODE_HS) || slow_on;
  assign idle_tmr_en = (state != PS_HALT);
  assign mode_code   = mode;
  assign pwr_state   = state;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int CPI = 5,
  parameter int DLY = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_end,
  input logic       fast_rdy,
  input logic [1:0] mode_code,
  input logic [1:0] pwr_state,
  input logic       core_clk_en,
  input logic       fast_osc_en,
  input logic       slow_osc_en,
  input logic       idle_tmr_en
);

  int start_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             start_cnt <= 0;
    else if (pwr_state != 2'b11)            start_cnt <= 0;
    else if (fast_rdy)                      start_cnt <= start_cnt + 1;
  end

  a_r8_core_gated_off_run: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'b00) |-> !core_clk_en);

  a_r7_halt_stops_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01) |-> (!fast_osc_en && !idle_tmr_en));

  a_r5_dual_keeps_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b10) |-> slow_osc_en);

  a_r4_dual_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_code) == 2'b10) |-> (mode_code == 2'b10));

  a_r6_halt_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01 && $past(pwr_state) != 2'b01) |->
      ($past(pwr_state) == 2'b00 && $past(cyc_end)));

  a_r8_start_length: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && $past(pwr_state) == 2'b11) |-> (start_cnt == CPI * DLY));

  a_r8_start_fast_on: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b11) |-> fast_osc_en);

  a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code != 2'b11);

endmodule

bind pwr_mode_ctrl pmc_checker #(.CPI(CPI), .DLY(DLY)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_end     (cyc_end),
  .fast_rdy    (fast_rdy),
  .mode_code   (mode_code),
  .pwr_state   (pwr_state),
  .core_clk_en (core_clk_en),
  .fast_osc_en (fast_osc_en),
  .slow_osc_en (slow_osc_en),
  .idle_tmr_en (idle_tmr_en)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, port_we = 0, cyc_end = 0, wake_evt = 0, idle_tick = 0;
  logic fast_rdy = 1, slow_rdy = 0, halt_dis = 0;
  logic [3:0] cfg_wdata = '0;
  logic [7:0] port_wdata = '0;
  logic core_clk_en, fast_osc_en, slow_osc_en, idle_tmr_en;
  logic [1:0] mode_code, pwr_state;

  int checks = 0, failures = 0, cycles = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .port_we(port_we), .port_wdata(port_wdata), .cyc_end(cyc_end),
    .fast_rdy(fast_rdy), .slow_rdy(slow_rdy), .wake_evt(wake_evt),
    .idle_tick(idle_tick), .halt_dis(halt_dis),
    .core_clk_en(core_clk_en), .fast_osc_en(fast_osc_en),
    .slow_osc_en(slow_osc_en), .idle_tmr_en(idle_tmr_en),
    .mode_code(mode_code), .pwr_state(pwr_state)
  );

  // Behavioural reference: integers for mode/state, one flat start-up count.
  int m_mode, m_ps, m_cnt;
  bit m_fon, m_son, m_hq, m_iq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ps = 0; m_cnt = 0;
      m_fon = 1; m_son = 0; m_hq = 0; m_iq = 0;
    end else begin
      int nm, np;
      bit taken;
      nm = m_mode; np = m_ps; taken = 0;
      if (cfg_we) begin
        if (m_mode == 0 && m_son && slow_rdy) begin
          if (cfg_wdata[2]) nm = 2;
          else if (cfg_wdata[3]) nm = 1;
        end else if (m_mode == 1 && !cfg_wdata[3] && m_fon && fast_rdy) nm = 2;
        m_fon = cfg_wdata[0];
        m_son = cfg_wdata[1];
      end
      m_mode = nm;
      case (m_ps)
        0: if (cyc_end && m_hq) begin np = 1; taken = 1; end
           else if (cyc_end && m_iq) begin np = 2; taken = 1; end
        1: if (wake_evt) begin np = 3; m_cnt = 0; end
        3: if (fast_rdy) begin m_cnt++; if (m_cnt == 1280) np = 0; end
        default: if (idle_tick) np = 0;
      endcase
      if (taken) begin m_hq = 0; m_iq = 0; end
      else begin
        m_hq = m_hq | (port_we & port_wdata[7] & !halt_dis);
        m_iq = m_iq | (port_we & port_wdata[6]);
      end
      m_ps = np;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(int'(mode_code), m_mode, "R2 model mode_code");
      chk(int'(pwr_state), m_ps, "R6 model pwr_state");
      chk(int'(core_clk_en), int'(m_ps == 0), "R8 model core_clk_en");
      chk(int'(fast_osc_en), int'(m_ps != 1 && (m_ps == 3 || m_mode != 1 || m_fon)), "R7 model fast_osc_en");
      chk(int'(slow_osc_en), int'(m_mode != 0 || m_son), "R5 model slow_osc_en");
      chk(int'(idle_tmr_en), int'(m_ps != 1), "R11 model idle_tmr_en");
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [3:0] d);
    cfg_we = 1; cfg_wdata = d; tick(1); cfg_we = 0; tick(1);
  endtask

  task automatic port_wr(input logic [7:0] d);
    port_we = 1; port_wdata = d; tick(1); port_we = 0; port_wdata = 0; tick(1);
  endtask

  task automatic boundary();
    cyc_end = 1; tick(1); cyc_end = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(3); rst_n = 1; tick(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1;
      failures++;
      $display("FAIL R8 watchdog cycles=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    // R1 reset values
    chk(mode_code, 0, "R1 mode after reset");
    chk(pwr_state, 0, "R1 state after reset");
    chk(core_clk_en, 1, "R1 core_clk_en");
    chk(fast_osc_en, 1, "R1 fast_osc_en");
    chk(slow_osc_en, 0, "R1 slow_osc_en");
    chk(idle_tmr_en, 1, "R1 idle_tmr_en");

    // R2 out of order: dual enable before slow enable
    cfg_wr(4'b0101);
    chk(mode_code, 0, "R2 dual without slow enable");
    cfg_wr(4'b0011);
    chk(slow_osc_en, 1, "R5 slow enable stored");
    cfg_wr(4'b0111);
    chk(mode_code, 0, "R2 dual without slow ready");
    slow_rdy = 1; tick(1);
    cfg_wr(4'b0111);
    chk(mode_code, 2, "R2 dual entered from fast");

    // R7 halt in dual, R8 wake with fast_rdy dropout
    port_wr(8'h80); tick(2);
    chk(pwr_state, 0, "R6 halt waits for boundary");
    boundary();
    chk(pwr_state, 1, "R6 halt taken");
    chk(slow_osc_en, 1, "R7 slow kept in dual halt");
    chk(fast_osc_en, 0, "R7 fast off in halt");
    chk(idle_tmr_en, 0, "R7 idle timer off in halt");
    tick(5);
    wake_evt = 1; tick(1); wake_evt = 0;
    chk(pwr_state, 3, "R8 start-up entered");
    n = 0;
    while (!core_clk_en && n < 5000) begin
      n++;
      if (n == 100) fast_rdy = 0;
      if (n == 120) fast_rdy = 1;
      tick(1);
    end
    chk(n, 1300, "R8 start-up length with 20 unready cycles");

    // R11 idle
    port_wr(8'h40); boundary();
    chk(pwr_state, 2, "R11 idle entered");
    chk(fast_osc_en, 1, "R11 fast on in idle");
    tick(4);
    idle_tick = 1; tick(1); idle_tick = 0;
    chk(pwr_state, 0, "R11 idle exit on tick");

    // R6 halt priority over idle
    port_wr(8'hC0); boundary();
    chk(pwr_state, 1, "R6 halt wins over idle");
    // R9 reset from halt
    do_reset();
    chk(mode_code, 0, "R9 reset to fast mode");
    chk(pwr_state, 0, "R9 reset to run");

    // R10 halt disabled
    halt_dis = 1; tick(1);
    port_wr(8'h80); boundary(); tick(1);
    chk(pwr_state, 0, "R10 halt ignored");
    halt_dis = 0; boundary(); tick(1);
    chk(pwr_state, 0, "R10 no stale halt request");

    // R4 fast -> slow, R3 slow -> dual ordering
    cfg_wr(4'b0011);
    cfg_wr(4'b1011);
    chk(mode_code, 1, "R4 slow mode entered");
    cfg_wr(4'b1010);
    chk(fast_osc_en, 0, "R5 fast off in slow mode");
    cfg_wr(4'b0010);
    chk(mode_code, 1, "R3 select cleared before fast enable");
    fast_rdy = 0;
    cfg_wr(4'b0011);
    cfg_wr(4'b0011);
    chk(mode_code, 1, "R3 fast not ready");
    fast_rdy = 1; tick(1);
    cfg_wr(4'b0011);
    chk(mode_code, 2, "R3 dual entered from slow");
    cfg_wr(4'b0001);
    chk(mode_code, 2, "R4 dual held");

    tick(3);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule